// File: doc/BRIEF.md
# Two-Wire Register Access Router

This block sits behind a two-wire serial slave and steers every byte access to its destination. The slave hands it one access at a time: an 8-bit device address, an 8-bit register address, a read/write flag and write data. The router decides whether the byte goes to the external EEPROM, to the internal diagnostic RAM, to both, or to a live hardware register it holds itself. It then issues one-cycle requests to the chosen destinations, waits for their completion strobes, and returns a single response with an acknowledge flag and read data.

Routing for the diagnostic device address depends on which half of the register space is addressed and on a write-only page selector that lives at register 7Fh. One register, the receive filter rate code at F5h, is kept in hardware inside the router. A write to it updates that hardware copy and also goes to RAM. A read of it returns the hardware copy. The router stays silent until the EEPROM boot transfer has finished. When the part runs in stand-alone mode, diagnostic reads return zero.

Top module: `twr_router`

## Requirements
- R1: Every access whose device address is A0h is sent to the EEPROM only. The access is acknowledged, `ee_dev` carries A0h, and a read returns the EEPROM data.
- R2: With page selector 00h or 01h, a read at device A2h of register 00h–7Eh goes to RAM only and returns the RAM data. A write there goes to both RAM and EEPROM.
- R3: With page selector 00h or 01h, a write at A2h to 80h–FFh (other than F5h) goes to EEPROM only. A read there is not acknowledged, returns 00h and raises no request.
- R4: With page selector 03h, reads and writes at A2h to 80h–FFh (other than F5h) go to RAM only.
- R5: A write at A2h to 7Fh loads the page selector. It is acknowledged and raises no request. A read of A2h:7Fh is acknowledged, returns 00h and raises no request.
- R6: A write at A2h to F5h updates the `rate_code` output and is also written to RAM, whatever the page selector holds. A read of A2h:F5h returns `rate_code` and raises no request.
- R7: Until `boot_done` has been seen high, `acc_ready` stays low. Offered accesses raise no request and no response.
- R8: While `standalone` is high, every read at A2h, including 7Fh and F5h, is acknowledged, returns 00h and raises no request. Writes at A2h are still routed normally.
- R9: Any other combination is not acknowledged, raises no request, and returns 00h for reads. This covers the lower half with page selector 03h, a page selector other than 00h, 01h or 03h, and a device address other than A0h or A2h.
- R10: For each routed access, every chosen destination sees exactly one single-cycle request. `resp_valid` pulses once, one cycle after the last completion strobe. `acc_ready` is low from acceptance until after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_done | input | 1 | EEPROM boot transfer finished |
| standalone | input | 1 | Stand-alone mode level |
| req_valid | input | 1 | Access offered by the slave |
| dev_addr | input | 8 | Device address byte (A0h or A2h) |
| reg_addr | input | 8 | Register address |
| is_write | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write data |
| acc_ready | output | 1 | Router can accept an access |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ack | output | 1 | Access acknowledged |
| resp_rdata | output | 8 | Read data |
| rate_code | output | 8 | Hardware rate register |
| ram_req | output | 1 | RAM request strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_done | input | 1 | RAM completion strobe |
| ram_rdata | input | 8 | RAM read data |
| ee_req | output | 1 | EEPROM request strobe |
| ee_we | output | 1 | EEPROM write enable |
| ee_dev | output | 8 | EEPROM device address |
| ee_addr | output | 8 | EEPROM register address |
| ee_wdata | output | 8 | EEPROM write data |
| ee_done | input | 1 | EEPROM completion strobe |
| ee_rdata | input | 8 | EEPROM read data |

## Verification
The hardest case to reach is a dual-destination write, where RAM and EEPROM finish at different times. The response must wait for the slower of the two, and each destination must see its request only once. The bench models RAM and EEPROM with different latencies, so every lower-half write exercises this case. A second hard case depends on the page selector, which cannot be read back. The only way to observe it is through routing, so the stimulus writes 7Fh and then probes the same upper and lower addresses under each selector value. Checking which destinations respond shows whether the selector took effect.

// File: rtl/twr_router_pkg.sv
package twr_router_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} rtr_state_e;

  typedef struct packed {
    logic to_ram;
    logic to_ee;
    logic ack;
    logic set_page;
    logic set_rate;
    logic rd_rate;
  } rtr_route_t;
endpackage

// File: rtl/twr_route_decode.sv
module twr_route_decode
  import twr_router_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [7:0] DEV_EE = 8'hA0,
  parameter logic [7:0] DEV_DIAG = 8'hA2,
  parameter logic [AW-1:0] PAGE_ADDR = 8'h7F,
  parameter logic [AW-1:0] RATE_ADDR = 8'hF5,
  parameter logic [DW-1:0] PG_BASE_A = 8'h00,
  parameter logic [DW-1:0] PG_BASE_B = 8'h01,
  parameter logic [DW-1:0] PG_UPPER = 8'h03
) (
  input  logic [7:0]    dev_addr,
  input  logic [AW-1:0] reg_addr,
  input  logic          is_write,
  input  logic [DW-1:0] page_sel,
  input  logic          standalone,
  output rtr_route_t    route
);
  logic upper_half, pg_base, pg_up;
  assign upper_half = reg_addr[AW-1];
  assign pg_base    = (page_sel == PG_BASE_A) || (page_sel == PG_BASE_B);
  assign pg_up      = (page_sel == PG_UPPER);

  always_comb begin
    route = '0;
    if (dev_addr == DEV_EE) begin
      route.to_ee = 1'b1;
      route.ack   = 1'b1;
    end else if (dev_addr == DEV_DIAG) begin
      if (!is_write && standalone) begin
        route.ack = 1'b1;
      end else if (reg_addr == PAGE_ADDR) begin
        route.ack      = 1'b1;
        route.set_page = is_write;
      end else if (reg_addr == RATE_ADDR) begin
        route.ack = 1'b1;
        if (is_write) begin
          route.set_rate = 1'b1;
          route.to_ram   = 1'b1;
        end else begin
          route.rd_rate = 1'b1;
        end
      end else if (!upper_half && pg_base) begin
        route.ack    = 1'b1;
        route.to_ram = 1'b1;
        route.to_ee  = is_write;
      end else if (upper_half && pg_base && is_write) begin
        route.ack   = 1'b1;
        route.to_ee = 1'b1;
      end else if (upper_half && pg_up) begin
        route.ack    = 1'b1;
        route.to_ram = 1'b1;
      end
    end
  end
endmodule

// File: rtl/twr_state_regs.sv
module twr_state_regs
  import twr_router_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_done,
  input  logic          accept,
  input  rtr_route_t    route,
  input  logic [DW-1:0] wdata,
  output logic          booted,
  output logic [DW-1:0] page_sel,
  output logic [DW-1:0] rate_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      booted    <= 1'b0;
      page_sel  <= '0;
      rate_code <= '0;
    end else begin
      if (boot_done) booted <= 1'b1;
      if (accept && route.set_page) page_sel <= wdata;
      if (accept && route.set_rate) rate_code <= wdata;
    end
  end

  // R6
  rate_update_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && route.set_rate) |=> (rate_code == $past(wdata)));

  // R7
  boot_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    booted |=> booted);
endmodule

// File: rtl/twr_access_seq.sv
module twr_access_seq
  import twr_router_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          booted,
  input  logic          req_valid,
  input  logic [7:0]    dev_addr,
  input  logic [AW-1:0] reg_addr,
  input  logic          is_write,
  input  logic [DW-1:0] wdata,
  input  rtr_route_t    route,
  input  logic [DW-1:0] rate_code,
  output logic          accept,
  output logic          acc_ready,
  output logic          resp_valid,
  output logic          resp_ack,
  output logic [DW-1:0] resp_rdata,
  output logic          ram_req,
  output logic          ee_req,
  output logic          we_q,
  output logic [7:0]    dev_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  input  logic          ram_done,
  input  logic [DW-1:0] ram_rdata,
  input  logic          ee_done,
  input  logic [DW-1:0] ee_rdata
);
  rtr_state_e state;
  logic pend_ram, pend_ee;
  logic left_ram, left_ee;

  assign acc_ready  = booted && (state == ST_IDLE);
  assign accept     = req_valid && acc_ready;
  assign resp_valid = (state == ST_RESP);
  assign left_ram   = pend_ram && !ram_done;
  assign left_ee    = pend_ee && !ee_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      pend_ram   <= 1'b0;
      pend_ee    <= 1'b0;
      ram_req    <= 1'b0;
      ee_req     <= 1'b0;
      resp_ack   <= 1'b0;
      resp_rdata <= '0;
      we_q       <= 1'b0;
      dev_q      <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else begin
      ram_req <= 1'b0;
      ee_req  <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          we_q       <= is_write;
          dev_q      <= dev_addr;
          addr_q     <= reg_addr;
          wdata_q    <= wdata;
          ram_req    <= route.to_ram;
          ee_req     <= route.to_ee;
          pend_ram   <= route.to_ram;
          pend_ee    <= route.to_ee;
          resp_ack   <= route.ack;
          resp_rdata <= route.rd_rate ? rate_code : '0;
          state      <= (route.to_ram || route.to_ee) ? ST_WAIT : ST_RESP;
        end
        ST_WAIT: begin
          if (pend_ram && ram_done) begin
            pend_ram <= 1'b0;
            if (!we_q) resp_rdata <= ram_rdata;
          end
          if (pend_ee && ee_done) begin
            pend_ee <= 1'b0;
            if (!we_q) resp_rdata <= ee_rdata;
          end
          if (!left_ram && !left_ee) state <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  ram_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ram_req |=> !ram_req);

  // R10
  ee_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ee_req |=> !ee_req);

  // R10
  busy_resp_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !acc_ready);

  // R10
  wait_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> (pend_ram || pend_ee));

  // R7
  silent_boot_chk: assert property (@(posedge clk) disable iff (rst)
    !booted |-> (!ram_req && !ee_req && !resp_valid));
endmodule

// File: rtl/twr_router.sv
module twr_router
  import twr_router_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [7:0] DEV_EE = 8'hA0,
  parameter logic [7:0] DEV_DIAG = 8'hA2,
  parameter logic [AW-1:0] PAGE_ADDR = 8'h7F,
  parameter logic [AW-1:0] RATE_ADDR = 8'hF5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_done,
  input  logic          standalone,
  input  logic          req_valid,
  input  logic [7:0]    dev_addr,
  input  logic [AW-1:0] reg_addr,
  input  logic          is_write,
  input  logic [DW-1:0] wdata,
  output logic          acc_ready,
  output logic          resp_valid,
  output logic          resp_ack,
  output logic [DW-1:0] resp_rdata,
  output logic [DW-1:0] rate_code,
  output logic          ram_req,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic          ram_done,
  input  logic [DW-1:0] ram_rdata,
  output logic          ee_req,
  output logic          ee_we,
  output logic [7:0]    ee_dev,
  output logic [AW-1:0] ee_addr,
  output logic [DW-1:0] ee_wdata,
  input  logic          ee_done,
  input  logic [DW-1:0] ee_rdata
);
  rtr_route_t    route;
  logic          booted, accept, we_q;
  logic [7:0]    dev_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, page_sel;

  twr_route_decode #(
    .AW(AW), .DW(DW), .DEV_EE(DEV_EE), .DEV_DIAG(DEV_DIAG),
    .PAGE_ADDR(PAGE_ADDR), .RATE_ADDR(RATE_ADDR)
  ) u_decode (
    .dev_addr(dev_addr), .reg_addr(reg_addr), .is_write(is_write),
    .page_sel(page_sel), .standalone(standalone), .route(route)
  );

  twr_state_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .boot_done(boot_done), .accept(accept),
    .route(route), .wdata(wdata), .booted(booted),
    .page_sel(page_sel), .rate_code(rate_code)
  );

  twr_access_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .booted(booted), .req_valid(req_valid),
    .dev_addr(dev_addr), .reg_addr(reg_addr), .is_write(is_write),
    .wdata(wdata), .route(route), .rate_code(rate_code),
    .accept(accept), .acc_ready(acc_ready), .resp_valid(resp_valid),
    .resp_ack(resp_ack), .resp_rdata(resp_rdata),
    .ram_req(ram_req), .ee_req(ee_req), .we_q(we_q), .dev_q(dev_q),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .ram_done(ram_done), .ram_rdata(ram_rdata),
    .ee_done(ee_done), .ee_rdata(ee_rdata)
  );

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;
  assign ee_we     = we_q;
  assign ee_dev    = dev_q;
  assign ee_addr   = addr_q;
  assign ee_wdata  = wdata_q;

  // R1
  ee_only_chk: assert property (@(posedge clk) disable iff (rst)
    (ee_req && ee_dev == DEV_EE) |-> !ram_req);

  // R5
  page_write_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && is_write && dev_addr == DEV_DIAG && reg_addr == PAGE_ADDR)
      |=> (!ram_req && !ee_req));

  // R8
  standalone_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !is_write && standalone && dev_addr == DEV_DIAG)
      |=> (resp_valid && resp_rdata == '0 && !ram_req && !ee_req));
endmodule

// File: tb/twr_router_tb.sv
`timescale 1ns/1ps
module twr_router_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boot_done = 1'b0, standalone = 1'b0, req_valid = 1'b0, is_write = 1'b0;
  logic [7:0] dev_addr = '0, reg_addr = '0, wdata = '0;
  logic acc_ready, resp_valid, resp_ack, ram_req, ram_we, ee_req, ee_we;
  logic [7:0] resp_rdata, rate_code, ram_addr, ram_wdata, ee_dev, ee_addr, ee_wdata;
  logic ram_done = 1'b0, ee_done = 1'b0;
  logic [7:0] ram_rdata = '0, ee_rdata = '0;

  always #2 clk = ~clk;

  twr_router u_dut (
    .clk(clk), .rst(rst), .boot_done(boot_done), .standalone(standalone),
    .req_valid(req_valid), .dev_addr(dev_addr), .reg_addr(reg_addr),
    .is_write(is_write), .wdata(wdata), .acc_ready(acc_ready),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_rdata(resp_rdata),
    .rate_code(rate_code), .ram_req(ram_req), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_done(ram_done),
    .ram_rdata(ram_rdata), .ee_req(ee_req), .ee_we(ee_we), .ee_dev(ee_dev),
    .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_done(ee_done),
    .ee_rdata(ee_rdata)
  );

  // destination models: RAM answers in 2 cycles, EEPROM in 4
  logic [7:0] ram_mem [256];
  logic [7:0] ee_mem [512];
  int ram_cnt = 0, ee_cnt = 0;
  logic [7:0] ram_la, ram_lw; logic ram_lwe;
  logic [8:0] ee_la; logic [7:0] ee_lw; logic ee_lwe;

  always @(posedge clk) begin
    ram_done <= 1'b0;
    if (ram_req) begin
      ram_cnt <= 2; ram_la <= ram_addr; ram_lw <= ram_wdata; ram_lwe <= ram_we;
    end else if (ram_cnt != 0) begin
      ram_cnt <= ram_cnt - 1;
      if (ram_cnt == 1) begin
        ram_done <= 1'b1; ram_rdata <= ram_mem[ram_la];
        if (ram_lwe) ram_mem[ram_la] <= ram_lw;
      end
    end
    ee_done <= 1'b0;
    if (ee_req) begin
      ee_cnt <= 4; ee_la <= {ee_dev[1], ee_addr}; ee_lw <= ee_wdata; ee_lwe <= ee_we;
    end else if (ee_cnt != 0) begin
      ee_cnt <= ee_cnt - 1;
      if (ee_cnt == 1) begin
        ee_done <= 1'b1; ee_rdata <= ee_mem[ee_la];
        if (ee_lwe) ee_mem[ee_la] <= ee_lw;
      end
    end
  end

  typedef struct packed {
    logic       ack;
    logic [7:0] rdata;
    logic       to_ram;
    logic       to_ee;
    logic [7:0] dev;
  } exp_t;
  exp_t exp_q[$];
  string tag_q[$];

  int n_checks = 0, n_fail = 0;
  int seen_ram = 0, seen_ee = 0, seen_resp = 0;
  logic [7:0] seen_dev = '0;

  task automatic check(input string tag, input bit ok, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: counts requests and compares each response with the queue head
  always @(negedge clk) begin
    if (!rst) begin
      if (ram_req) seen_ram++;
      if (ee_req) begin seen_ee++; seen_dev = ee_dev; end
      if (resp_valid) begin
        seen_resp++;
        if (exp_q.size() == 0) begin
          check("R7", 1'b0, "unexpected response", 1, 0);
        end else begin
          exp_t e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(t, resp_ack == e.ack, "ack", int'(resp_ack), int'(e.ack));
          check(t, resp_rdata == e.rdata, "rdata", int'(resp_rdata), int'(e.rdata));
          check(t, seen_ram == int'(e.to_ram), "ram requests", seen_ram, int'(e.to_ram));
          check(t, seen_ee == int'(e.to_ee), "eeprom requests", seen_ee, int'(e.to_ee));
          if (e.to_ee)
            check(t, seen_dev == e.dev, "eeprom device", int'(seen_dev), int'(e.dev));
          check(t, acc_ready == 1'b0, "ready during response", int'(acc_ready), 0);
        end
        seen_ram = 0; seen_ee = 0;
      end
    end
  end

  task automatic access(input string tag, input logic [7:0] dv, input logic [7:0] ad,
                        input logic wr, input logic [7:0] wd, input logic ack,
                        input logic [7:0] rd, input logic to_ram, input logic to_ee);
    exp_t e;
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    e.ack = ack; e.rdata = rd; e.to_ram = to_ram; e.to_ee = to_ee; e.dev = dv;
    exp_q.push_back(e); tag_q.push_back(tag);
    dev_addr = dv; reg_addr = ad; is_write = wr; wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7", acc_ready == 1'b0, "reset ready", int'(acc_ready), 0);
    check("R6", rate_code == 8'h00, "reset rate_code", int'(rate_code), 0);
    check("R10", resp_valid == 1'b0, "reset resp_valid", int'(resp_valid), 0);

    // R7: offer an access before boot; nothing may happen
    dev_addr = 8'hA2; reg_addr = 8'h20; is_write = 1'b1; wdata = 8'h11; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    check("R7", (seen_ram + seen_ee + seen_resp) == 0, "activity before boot",
          seen_ram + seen_ee + seen_resp, 0);
    check("R7", acc_ready == 1'b0, "ready before boot", int'(acc_ready), 0);
    boot_done = 1'b1;
    @(negedge clk);
    check("R7", acc_ready == 1'b1, "ready after boot", int'(acc_ready), 1);

    // R1: device A0h goes only to the EEPROM
    access("R1", 8'hA0, 8'h10, 1'b1, 8'h5A, 1'b1, 8'h00, 1'b0, 1'b1);
    access("R1", 8'hA0, 8'h10, 1'b0, 8'h00, 1'b1, 8'h5A, 1'b0, 1'b1);
    access("R1", 8'hA0, 8'hC0, 1'b1, 8'h3C, 1'b1, 8'h00, 1'b0, 1'b1);
    // R2: lower half, page 00h
    access("R2", 8'hA2, 8'h20, 1'b1, 8'h33, 1'b1, 8'h00, 1'b1, 1'b1);
    access("R2", 8'hA2, 8'h20, 1'b0, 8'h00, 1'b1, 8'h33, 1'b1, 1'b0);
    // R3: upper half, page 00h
    access("R3", 8'hA2, 8'h90, 1'b1, 8'h44, 1'b1, 8'h00, 1'b0, 1'b1);
    access("R3", 8'hA2, 8'h90, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
    // R5: page selector write and read-back
    access("R5", 8'hA2, 8'h7F, 1'b1, 8'h03, 1'b1, 8'h00, 1'b0, 1'b0);
    access("R5", 8'hA2, 8'h7F, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
    // R4: upper half, page 03h
    access("R4", 8'hA2, 8'h90, 1'b1, 8'h66, 1'b1, 8'h00, 1'b1, 1'b0);
    access("R4", 8'hA2, 8'h90, 1'b0, 8'h00, 1'b1, 8'h66, 1'b1, 1'b0);
    // R9: lower half under page 03h
    access("R9", 8'hA2, 8'h20, 1'b1, 8'h99, 1'b0, 8'h00, 1'b0, 1'b0);
    access("R9", 8'hA2, 8'h20, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
    // R9: page 02h and an unknown device
    access("R5", 8'hA2, 8'h7F, 1'b1, 8'h02, 1'b1, 8'h00, 1'b0, 1'b0);
    access("R9", 8'hA2, 8'h20, 1'b1, 8'h98, 1'b0, 8'h00, 1'b0, 1'b0);
    access("R9", 8'hA2, 8'h90, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
    access("R9", 8'hB0, 8'h20, 1'b1, 8'h97, 1'b0, 8'h00, 1'b0, 1'b0);
    // R6: rate register under page 02h
    access("R6", 8'hA2, 8'hF5, 1'b1, 8'h2D, 1'b1, 8'h00, 1'b1, 1'b0);
    drain();
    check("R6", rate_code == 8'h2D, "rate_code after write", int'(rate_code), 8'h2D);
    access("R6", 8'hA2, 8'hF5, 1'b0, 8'h00, 1'b1, 8'h2D, 1'b0, 1'b0);
    // R2: page 01h routes like 00h; earlier nacked writes left 33h in place
    access("R5", 8'hA2, 8'h7F, 1'b1, 8'h01, 1'b1, 8'h00, 1'b0, 1'b0);
    access("R2", 8'hA2, 8'h20, 1'b0, 8'h00, 1'b1, 8'h33, 1'b1, 1'b0);
    // R3: upper-half write under page 01h stays EEPROM only
    access("R3", 8'hA2, 8'hA4, 1'b1, 8'h12, 1'b1, 8'h00, 1'b0, 1'b1);
    // R8: stand-alone reads give zero; writes still routed
    drain();
    standalone = 1'b1;
    access("R8", 8'hA2, 8'h20, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
    access("R8", 8'hA2, 8'hF5, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
    access("R8", 8'hA2, 8'h21, 1'b1, 8'h77, 1'b1, 8'h00, 1'b1, 1'b1);
    access("R1", 8'hA0, 8'h10, 1'b0, 8'h00, 1'b1, 8'h5A, 1'b0, 1'b1);
    drain();
    standalone = 1'b0;
    access("R8", 8'hA2, 8'h21, 1'b0, 8'h00, 1'b1, 8'h77, 1'b1, 1'b0);
    drain();
    check("R6", rate_code == 8'h2D, "rate_code kept", int'(rate_code), 8'h2D);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule